// File: doc/BRIEF.md
# Multi-cycle 32-bit integer core

A small, non-pipelined processor core for a 32-bit load/store integer instruction encoding. Every instruction takes one word fetch at the program counter and then one execute step. Loads and stores add one data access on the same shared memory port. The core holds 32 general registers, with register 0 hard-wired to zero, and a program counter that starts at a parameterised reset vector. Nothing traps. An opcode or function field the core does not implement retires as a no-op.

The memory port is one valid/ready request channel. The request carries an address, a size code (1 = byte, 2 = halfword, 4 = word), a store flag and store data. A transfer completes on the rising clock edge where `bus_valid` and `bus_ready` are both high. Read data on `bus_rdata` must be valid in that same cycle. While `bus_ready` is low the core keeps its request in place, every field unchanged, and waits as long as it takes. The request cannot be withdrawn.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, `bus_valid` is low. The first request after reset is a word fetch (size 4, store flag 0) at address `RESET_VEC`.
- R2: Every request uses size code 1, 2 or 4. Instruction fetches always use size 4 with the store flag low, and the opcode sits in fetched bits [6:0].
- R3: A request with `bus_valid` high and `bus_ready` low is held in the next cycle with the same address, size, store flag and store data.
- R4: Register 0 always reads as zero. Writes to it are discarded.
- R5: Opcode 0x33 operates on two registers. funct3 values: 0 add (funct7 0x20 subtract), 1 shift left, 2 signed less-than, 3 unsigned less-than, 4 xor, 5 logical right shift (funct7 0x20 arithmetic), 6 or, 7 and. Shift amounts use rs2[4:0] only.
- R6: Opcode 0x13 uses the sign-extended immediate in bits [31:20] as the second operand, with the same funct3 meanings as R5 and no subtract. Shift amounts come from bits [24:20]. funct7 0x20 selects the arithmetic right shift.
- R7: Opcode 0x03 reads from rs1 plus the I-immediate. funct3 values: 0 signed byte, 1 signed halfword, 2 word, 4 unsigned byte, 5 unsigned halfword. Read data is right-aligned in `bus_rdata`, and bits above the access size are ignored.
- R8: Opcode 0x23 writes rs2 to rs1 plus the store immediate (bits [31:25] and [11:7]). funct3 values: 0 byte, 1 halfword, 2 word. The data is right-aligned in `bus_wdata`, and the unused upper bits are zero.
- R9: Opcode 0x37 writes bits [31:12] of the instruction, with 12 low zero bits, to rd. Opcode 0x17 writes that value plus the instruction's own address.
- R10: Opcode 0x6F writes PC+4 to rd and jumps to PC plus the J-immediate. Opcode 0x67 writes PC+4 to rd and jumps to rs1 plus the I-immediate with bit 0 cleared.
- R11: Opcode 0x63 compares rs1 with rs2. funct3 values: 0 equal, 1 not equal, 4 signed less, 5 signed greater-or-equal, 6 unsigned less, 7 unsigned greater-or-equal. When taken, PC becomes PC plus the B-immediate, otherwise PC+4. Backward offsets work.
- R12: Any other opcode, funct3 or funct7 combination changes no register and makes no data access, and PC advances by 4. This includes funct7 other than 0/0x20 on register add/subtract and on right shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | output | 1 | Request present |
| bus_ready | input | 1 | Memory accepts the request this cycle |
| bus_addr | output | 32 | Byte address |
| bus_size | output | 3 | Access size code: 1, 2 or 4 bytes |
| bus_store | output | 1 | High for a write |
| bus_wdata | output | 32 | Store data, right-aligned |
| bus_rdata | input | 32 | Read data, right-aligned, valid with `bus_ready` |

## Verification
The assertions assume that `bus_ready` is a free choice of the memory, and that read data is meaningful only in a cycle where a transfer completes. They also assume fetched programs keep word alignment, so fetch addresses stay multiples of four. The stimulus drives `bus_ready` from a pseudo-random sequence, so stalls of varying length land on fetches, loads and stores alike. The memory model returns the addressed word shifted down to the byte lane, which leaves unrelated bytes in the upper bits so the core's masking and extension are exercised. Every program jump target used by the stimulus is word-aligned.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN     = 32;
  localparam int REG_CNT  = 32;
  localparam int RIDX     = $clog2(REG_CNT);
  localparam int RD_PORTS = 2;

  localparam logic [6:0] OPC_LOAD  = 7'h03;
  localparam logic [6:0] OPC_STORE = 7'h23;
  localparam logic [6:0] OPC_IMM   = 7'h13;
  localparam logic [6:0] OPC_REG   = 7'h33;
  localparam logic [6:0] OPC_LUI   = 7'h37;
  localparam logic [6:0] OPC_AUIPC = 7'h17;
  localparam logic [6:0] OPC_JAL   = 7'h6F;
  localparam logic [6:0] OPC_JALR  = 7'h67;
  localparam logic [6:0] OPC_BR    = 7'h63;

  localparam logic [2:0] SZ_B = 3'd1;
  localparam logic [2:0] SZ_H = 3'd2;
  localparam logic [2:0] SZ_W = 3'd4;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU,
    OP_XOR, OP_SRL, OP_SRA, OP_OR, OP_AND
  } alu_op_e;

  typedef enum logic [3:0] {
    K_NOP, K_ALU, K_LOAD, K_STORE, K_LUI,
    K_AUIPC, K_JAL, K_JALR, K_BRANCH
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    alu_op_e          op;
    logic             use_imm;
    logic [XLEN-1:0]  imm;
    logic [RIDX-1:0]  rd;
    logic [RIDX-1:0]  rs1;
    logic [RIDX-1:0]  rs2;
    logic [2:0]       f3;
  } dec_t;

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_MEM} state_e;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        d
);
  logic [6:0]      opc;
  logic [2:0]      f3;
  logic [6:0]      f7;
  logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_u, imm_j;

  assign opc   = insn[6:0];
  assign f3    = insn[14:12];
  assign f7    = insn[31:25];
  assign imm_i = {{20{insn[31]}}, insn[31:20]};
  assign imm_s = {{20{insn[31]}}, insn[31:25], insn[11:7]};
  assign imm_b = {{19{insn[31]}}, insn[31], insn[7], insn[30:25], insn[11:8], 1'b0};
  assign imm_u = {insn[31:12], 12'b0};
  assign imm_j = {{11{insn[31]}}, insn[31], insn[19:12], insn[20], insn[30:21], 1'b0};

  always_comb begin
    d.kind    = K_NOP;
    d.op      = OP_ADD;
    d.use_imm = 1'b0;
    d.imm     = imm_i;
    d.rd      = insn[11:7];
    d.rs1     = insn[19:15];
    d.rs2     = insn[24:20];
    d.f3      = f3;
    case (opc)
      OPC_LOAD: begin
        d.use_imm = 1'b1;
        if (f3 inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd5}) d.kind = K_LOAD;
      end
      OPC_STORE: begin
        d.use_imm = 1'b1;
        d.imm     = imm_s;
        if (f3 <= 3'd2) d.kind = K_STORE;
      end
      OPC_IMM, OPC_REG: begin
        d.kind    = K_ALU;
        d.use_imm = (opc == OPC_IMM);
        case (f3)
          3'd0: begin
            if (opc == OPC_REG) begin
              if (f7 == 7'h20)      d.op = OP_SUB;
              else if (f7 != 7'h00) d.kind = K_NOP;
            end
          end
          3'd1: d.op = OP_SLL;
          3'd2: d.op = OP_SLT;
          3'd3: d.op = OP_SLTU;
          3'd4: d.op = OP_XOR;
          3'd5: begin
            if (f7 == 7'h20)      d.op = OP_SRA;
            else if (f7 == 7'h00) d.op = OP_SRL;
            else                  d.kind = K_NOP;
          end
          3'd6: d.op = OP_OR;
          default: d.op = OP_AND;
        endcase
      end
      OPC_LUI: begin
        d.kind = K_LUI;
        d.imm  = imm_u;
      end
      OPC_AUIPC: begin
        d.kind    = K_AUIPC;
        d.imm     = imm_u;
        d.use_imm = 1'b1;
      end
      OPC_JAL: begin
        d.kind = K_JAL;
        d.imm  = imm_j;
      end
      OPC_JALR: d.kind = K_JALR;
      OPC_BR: begin
        d.imm = imm_b;
        if (f3 != 3'd2 && f3 != 3'd3) d.kind = K_BRANCH;
      end
      default: d.kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         eq,
  output logic         lt,
  output logic         ltu
);
  localparam int SHW = $clog2(W);
  logic [SHW-1:0] sh;

  assign sh  = b[SHW-1:0];
  assign eq  = (a == b);
  assign lt  = ($signed(a) < $signed(b));
  assign ltu = (a < b);

  always_comb begin
    case (op)
      OP_SUB:  y = a - b;
      OP_SLL:  y = a << sh;
      OP_SLT:  y = {{(W-1){1'b0}}, lt};
      OP_SLTU: y = {{(W-1){1'b0}}, ltu};
      OP_XOR:  y = a ^ b;
      OP_SRL:  y = a >> sh;
      OP_SRA:  y = $unsigned($signed(a) >>> sh);
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG  = 32,
  parameter int W     = 32,
  parameter int NPORT = 2,
  localparam int AW   = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NPORT-1:0][AW-1:0]  ra,
  output logic [NPORT-1:0][W-1:0]   rdata,
  input  logic                      we,
  input  logic [AW-1:0]             wa,
  input  logic [W-1:0]              wd
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    assign rdata[p] = (ra[p] == '0) ? '0 : regs[ra[p]];
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
  input  logic        clk,
  input  logic        rst,
  output logic        bus_valid,
  input  logic        bus_ready,
  output logic [31:0] bus_addr,
  output logic [2:0]  bus_size,
  output logic        bus_store,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata
);
  state_e          state;
  logic [XLEN-1:0] pc_q, ir_q, maddr_q, mwdata_q;
  logic [2:0]      msize_q;
  logic            mstore_q;

  dec_t            dec;
  logic [RD_PORTS-1:0][RIDX-1:0] rf_ra;
  logic [RD_PORTS-1:0][XLEN-1:0] rf_rv;
  logic [XLEN-1:0] rs1_v, rs2_v;
  logic            rf_we;
  logic [XLEN-1:0] rf_wd;

  logic [XLEN-1:0] alu_a, alu_b, alu_y;
  logic            c_eq, c_lt, c_ltu;
  logic [XLEN-1:0] pc_plus4, tgt_sum, tgt, pc_next;
  logic            take;
  logic [XLEN-1:0] ld_val, st_data;
  logic [2:0]      acc_size;

  sc_decode u_dec (.insn(ir_q), .d(dec));

  assign rf_ra = {dec.rs2, dec.rs1};
  assign rs1_v = rf_rv[0];
  assign rs2_v = rf_rv[1];

  sc_regfile #(.NREG(REG_CNT), .W(XLEN), .NPORT(RD_PORTS)) u_rf (
    .clk(clk), .rst(rst), .ra(rf_ra), .rdata(rf_rv),
    .we(rf_we), .wa(dec.rd), .wd(rf_wd)
  );

  assign alu_a = (dec.kind == K_AUIPC) ? pc_q : rs1_v;
  assign alu_b = dec.use_imm ? dec.imm : rs2_v;

  sc_alu #(.W(XLEN)) u_alu (
    .a(alu_a), .b(alu_b), .op(dec.op), .y(alu_y),
    .eq(c_eq), .lt(c_lt), .ltu(c_ltu)
  );

  assign pc_plus4 = pc_q + XLEN'(4);
  assign tgt_sum  = ((dec.kind == K_JALR) ? rs1_v : pc_q) + dec.imm;
  assign tgt      = (dec.kind == K_JALR) ? {tgt_sum[XLEN-1:1], 1'b0} : tgt_sum;

  always_comb begin
    case (dec.f3)
      3'd0:    take = c_eq;
      3'd1:    take = !c_eq;
      3'd4:    take = c_lt;
      3'd5:    take = !c_lt;
      3'd6:    take = c_ltu;
      3'd7:    take = !c_ltu;
      default: take = 1'b0;
    endcase
  end

  always_comb begin
    if (dec.kind == K_JAL || dec.kind == K_JALR || (dec.kind == K_BRANCH && take))
      pc_next = tgt;
    else
      pc_next = pc_plus4;
  end

  always_comb begin
    case (dec.f3[1:0])
      2'd0:    acc_size = SZ_B;
      2'd1:    acc_size = SZ_H;
      default: acc_size = SZ_W;
    endcase
  end

  always_comb begin
    case (dec.f3[1:0])
      2'd0:    st_data = {{(XLEN-8){1'b0}}, rs2_v[7:0]};
      2'd1:    st_data = {{(XLEN-16){1'b0}}, rs2_v[15:0]};
      default: st_data = rs2_v;
    endcase
  end

  always_comb begin
    case (dec.f3)
      3'd0:    ld_val = {{(XLEN-8){bus_rdata[7]}}, bus_rdata[7:0]};
      3'd1:    ld_val = {{(XLEN-16){bus_rdata[15]}}, bus_rdata[15:0]};
      3'd4:    ld_val = {{(XLEN-8){1'b0}}, bus_rdata[7:0]};
      3'd5:    ld_val = {{(XLEN-16){1'b0}}, bus_rdata[15:0]};
      default: ld_val = bus_rdata;
    endcase
  end

  always_comb begin
    rf_we = 1'b0;
    rf_wd = alu_y;
    if (state == S_EXEC) begin
      case (dec.kind)
        K_ALU, K_AUIPC: rf_we = 1'b1;
        K_LUI: begin
          rf_we = 1'b1;
          rf_wd = dec.imm;
        end
        K_JAL, K_JALR: begin
          rf_we = 1'b1;
          rf_wd = pc_plus4;
        end
        default: rf_we = 1'b0;
      endcase
    end else if (state == S_MEM && bus_ready && !mstore_q) begin
      rf_we = 1'b1;
      rf_wd = ld_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_FETCH;
      pc_q     <= RESET_VEC;
      ir_q     <= '0;
      maddr_q  <= '0;
      mwdata_q <= '0;
      msize_q  <= SZ_W;
      mstore_q <= 1'b0;
    end else begin
      case (state)
        S_FETCH: begin
          if (bus_ready) begin
            ir_q  <= bus_rdata;
            state <= S_EXEC;
          end
        end
        S_EXEC: begin
          if (dec.kind == K_LOAD || dec.kind == K_STORE) begin
            maddr_q  <= alu_y;
            msize_q  <= acc_size;
            mstore_q <= (dec.kind == K_STORE);
            mwdata_q <= st_data;
            state    <= S_MEM;
          end else begin
            pc_q  <= pc_next;
            state <= S_FETCH;
          end
        end
        S_MEM: begin
          if (bus_ready) begin
            pc_q  <= pc_plus4;
            state <= S_FETCH;
          end
        end
        default: state <= S_FETCH;
      endcase
    end
  end

  assign bus_valid = !rst && (state != S_EXEC);
  assign bus_addr  = (state == S_MEM) ? maddr_q : pc_q;
  assign bus_size  = (state == S_MEM) ? msize_q : SZ_W;
  assign bus_store = (state == S_MEM) && mstore_q;
  assign bus_wdata = (state == S_MEM && mstore_q) ? mwdata_q : '0;

  // R1: the first request after reset is a word fetch at the vector
  a_r1_first_fetch: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> bus_valid && bus_addr == RESET_VEC && bus_size == SZ_W && !bus_store);

  // R2: only the three legal size codes appear on the port
  a_r2_size_code: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (bus_size == SZ_B || bus_size == SZ_H || bus_size == SZ_W));

  // R3: a stalled request keeps every field
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_size)
                                && $stable(bus_store) && $stable(bus_wdata));

  // R8: narrow stores carry zeros above the access size
  a_r8_store_upper_zero: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_store && bus_size != SZ_W |->
      bus_wdata[31:16] == '0 && (bus_size == SZ_H || bus_wdata[15:8] == '0));

  // R12: sequential kinds and no-ops step the PC by four
  a_r12_seq_step: assert property (@(posedge clk) disable iff (rst)
    state == S_EXEC && dec.kind inside {K_NOP, K_ALU, K_LUI, K_AUIPC}
      |=> pc_q == $past(pc_q) + 32'd4);
endmodule

// File: tb/sc_core_test.sv
module sc_core_test;
  localparam logic [31:0] RV   = 32'h0000_0100;
  localparam int          WDOG = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid, bus_store;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [2:0]  bus_size;

  always #10 clk = ~clk;

  sc_core #(.RESET_VEC(RV)) uut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_store(bus_store),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  logic [31:0] mem [512];
  assign bus_rdata = mem[bus_addr[10:2]] >> {bus_addr[1:0], 3'b000};

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  typedef struct {
    logic [31:0] a;
    logic [2:0]  s;
    logic [31:0] d;
    string       tag;
  } item_t;
  item_t exp_q[$];

  task automatic push(input string tag, input logic [31:0] a, input logic [2:0] s,
                      input logic [31:0] d);
    item_t it;
    it.a = a; it.s = s; it.d = d; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // instruction encoders
  function automatic logic [31:0] e_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                      logic [2:0] f3, logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'h33};
  endfunction
  function automatic logic [31:0] e_i(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3,
                                      logic [4:0] rd, logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction
  function automatic logic [31:0] e_s(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                      logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] e_b(logic [12:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                      logic [2:0] f3);
    return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], 7'h63};
  endfunction
  function automatic logic [31:0] e_j(logic [20:0] imm, logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'h6F};
  endfunction

  int wp = 0;
  function automatic logic [31:0] here();
    return RV + 32'(4 * wp);
  endfunction
  task automatic emit(input logic [31:0] w);
    mem[int'(RV >> 2) + wp] = w;
    wp++;
  endtask
  // store word and expect it on the port
  task automatic sw_exp(input logic [4:0] rs, input logic [11:0] a, input string tag,
                        input logic [31:0] d);
    emit(e_s(a, rs, 5'd0, 3'd2));
    push(tag, {20'h0, a}, 3'd4, d);
  endtask
  task automatic bad_store();
    emit(e_s(12'h7F0, 5'd1, 5'd0, 3'd2));
  endtask

  // monitor: ready generator, stall holding, scoreboard compare
  logic [7:0]  lfsr = 8'h5A;
  logic        hold_pend = 1'b0;
  logic [31:0] h_addr, h_wdata;
  logic [3:0]  h_ctl;
  logic        first_done = 1'b0;
  logic [31:0] last_fetch = '0;
  int          cyc = 0;

  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bus_ready = lfsr[0] | lfsr[2];
    #1;
    if (rst) begin
      chk("R1 valid low in reset", {31'b0, bus_valid}, 32'd0);
    end else begin
      if (hold_pend) begin
        chk("R3 held addr", bus_addr, h_addr);
        chk("R3 held data", bus_wdata, h_wdata);
        chk("R3 held ctl", {28'b0, bus_valid, bus_size}, {28'b0, h_ctl});
        hold_pend = 1'b0;
      end
      if (bus_valid && !bus_ready) begin
        hold_pend = 1'b1;
        h_addr    = bus_addr;
        h_wdata   = bus_wdata;
        h_ctl     = {1'b1, bus_size};
      end
      if (bus_valid && bus_ready) begin
        if (!first_done) begin
          first_done = 1'b1;
          chk("R1 first fetch addr", bus_addr, RV);
          chk("R2 first fetch size/store", {28'b0, bus_size, bus_store}, {28'b0, 3'd4, 1'b0});
        end
        if (bus_store) begin
          logic [31:0] w;
          w = mem[bus_addr[10:2]];
          case (bus_size)
            3'd1:    w[{bus_addr[1:0], 3'b000} +: 8]  = bus_wdata[7:0];
            3'd2:    w[{bus_addr[1], 4'b0000} +: 16] = bus_wdata[15:0];
            default: w = bus_wdata;
          endcase
          mem[bus_addr[10:2]] = w;
          if (exp_q.size() == 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R12 unexpected store: got %08h expected none", bus_addr);
          end else begin
            item_t it;
            it = exp_q.pop_front();
            chk({it.tag, " addr"}, bus_addr, it.a);
            chk({it.tag, " size"}, {29'b0, bus_size}, {29'b0, it.s});
            chk({it.tag, " data"}, bus_wdata, it.d);
          end
        end else if (bus_addr < 32'h400) begin
          last_fetch = bus_addr;
        end
      end
    end
  end

  initial begin
    logic [31:0] p_auipc, p_jal, p_jalr, p_loop, p_end;
    for (int i = 0; i < 512; i++) mem[i] = '0;

    // arithmetic on registers and immediates
    emit(e_i(12'hFFB, 5'd0, 3'd0, 5'd1, 7'h13));            // x1 = -5
    emit(e_i(12'h003, 5'd0, 3'd0, 5'd2, 7'h13));            // x2 = 3
    emit(e_r(7'h20, 5'd2, 5'd1, 3'd0, 5'd3));               // x3 = x1 - x2
    sw_exp(5'd3, 12'h400, "R5 sub", 32'hFFFF_FFF8);
    emit(e_r(7'h20, 5'd2, 5'd1, 3'd5, 5'd4));               // sra
    emit(e_r(7'h00, 5'd2, 5'd1, 3'd5, 5'd5));               // srl
    sw_exp(5'd4, 12'h404, "R5 sra", 32'hFFFF_FFFF);
    sw_exp(5'd5, 12'h408, "R5 srl", 32'h1FFF_FFFF);
    emit(e_r(7'h00, 5'd2, 5'd1, 3'd2, 5'd6));               // slt -> 1
    emit(e_r(7'h00, 5'd2, 5'd1, 3'd3, 5'd7));               // sltu -> 0
    emit(e_s(12'h40C, 5'd6, 5'd0, 3'd0));                   // byte store
    push("R8 byte store", 32'h40C, 3'd1, 32'h0000_0001);
    emit(e_s(12'h40E, 5'd1, 5'd0, 3'd1));                   // half store
    push("R8 half store", 32'h40E, 3'd2, 32'h0000_FFFB);
    sw_exp(5'd7, 12'h410, "R5 sltu", 32'h0);
    emit(e_i(12'h004, 5'd2, 3'd1, 5'd9, 7'h13));            // slli 4
    emit(e_i(12'h401, 5'd1, 3'd5, 5'd10, 7'h13));           // srai 1
    sw_exp(5'd9, 12'h414, "R6 slli", 32'h0000_0030);
    sw_exp(5'd10, 12'h418, "R6 srai", 32'hFFFF_FFFD);
    emit(e_i(12'h024, 5'd0, 3'd0, 5'd11, 7'h13));           // x11 = 36
    emit(e_r(7'h00, 5'd11, 5'd2, 3'd1, 5'd12));             // sll by 36 -> by 4
    sw_exp(5'd12, 12'h41C, "R5 sll low five bits", 32'h0000_0030);
    emit(e_i(12'h0F0, 5'd1, 3'd4, 5'd24, 7'h13));           // xori
    emit(e_i(12'h7FF, 5'd1, 3'd7, 5'd25, 7'h13));           // andi
    sw_exp(5'd24, 12'h420, "R6 xori", 32'hFFFF_FF0B);
    sw_exp(5'd25, 12'h424, "R6 andi", 32'h0000_07FB);
    emit(e_i(12'hFFC, 5'd1, 3'd2, 5'd26, 7'h13));           // slti -5 < -4
    emit(e_i(12'hFFF, 5'd2, 3'd3, 5'd27, 7'h13));           // sltiu 3 < max
    sw_exp(5'd26, 12'h428, "R6 slti", 32'h1);
    sw_exp(5'd27, 12'h42C, "R6 sltiu", 32'h1);
    emit(e_r(7'h00, 5'd2, 5'd1, 3'd6, 5'd28));              // or
    emit(e_r(7'h00, 5'd2, 5'd1, 3'd7, 5'd29));              // and
    sw_exp(5'd28, 12'h430, "R5 or", 32'hFFFF_FFFB);
    sw_exp(5'd29, 12'h434, "R5 and", 32'h0000_0003);

    // upper immediates
    emit({20'h12345, 5'd13, 7'h37});
    sw_exp(5'd13, 12'h438, "R9 upper load", 32'h1234_5000);
    p_auipc = here();
    emit({20'h00001, 5'd14, 7'h17});
    sw_exp(5'd14, 12'h43C, "R9 pc relative", p_auipc + 32'h1000);

    // loads
    emit(e_i(12'h40E, 5'd0, 3'd1, 5'd15, 7'h03));
    emit(e_i(12'h40E, 5'd0, 3'd5, 5'd16, 7'h03));
    emit(e_i(12'h400, 5'd0, 3'd4, 5'd17, 7'h03));
    emit(e_i(12'h400, 5'd0, 3'd0, 5'd18, 7'h03));
    emit(e_i(12'h404, 5'd0, 3'd2, 5'd19, 7'h03));
    sw_exp(5'd15, 12'h440, "R7 signed half", 32'hFFFF_FFFB);
    sw_exp(5'd16, 12'h444, "R7 unsigned half", 32'h0000_FFFB);
    sw_exp(5'd17, 12'h448, "R7 unsigned byte", 32'h0000_00F8);
    sw_exp(5'd18, 12'h44C, "R7 signed byte", 32'hFFFF_FFF8);
    sw_exp(5'd19, 12'h450, "R7 word", 32'hFFFF_FFFF);

    // register zero
    emit(e_i(12'h005, 5'd0, 3'd0, 5'd0, 7'h13));
    sw_exp(5'd0, 12'h454, "R4 zero register", 32'h0);

    // branches
    emit(e_b(13'd8, 5'd2, 5'd2, 3'd0)); bad_store();         // beq taken
    emit(e_b(13'd8, 5'd2, 5'd1, 3'd4)); bad_store();         // blt taken
    emit(e_b(13'd8, 5'd2, 5'd1, 3'd6));                      // bltu not taken
    emit(e_i(12'h007, 5'd0, 3'd0, 5'd20, 7'h13));
    emit(e_b(13'd8, 5'd2, 5'd1, 3'd5));                      // bge not taken
    emit(e_b(13'd8, 5'd2, 5'd1, 3'd7)); bad_store();         // bgeu taken
    emit(e_b(13'd8, 5'd2, 5'd2, 3'd1));                      // bne not taken
    emit(e_i(12'h001, 5'd20, 3'd0, 5'd20, 7'h13));
    sw_exp(5'd20, 12'h458, "R11 branch outcomes", 32'd8);
    emit(e_i(12'h003, 5'd0, 3'd0, 5'd31, 7'h13));
    p_loop = here();
    emit(e_i(12'h002, 5'd30, 3'd0, 5'd30, 7'h13));
    emit(e_i(12'hFFF, 5'd31, 3'd0, 5'd31, 7'h13));
    emit(e_b(13'h1FF8, 5'd0, 5'd31, 3'd1));                  // back to loop
    sw_exp(5'd30, 12'h45C, "R11 backward loop", 32'd6);

    // jumps
    p_jal = here();
    emit(e_j(21'd8, 5'd21)); bad_store();
    sw_exp(5'd21, 12'h460, "R10 jump link", p_jal + 32'd4);
    p_jalr = here() + 32'd4;
    emit(e_i(12'(p_jalr + 32'd9), 5'd0, 3'd0, 5'd22, 7'h13)); // target+1
    emit(e_i(12'h000, 5'd22, 3'd0, 5'd23, 7'h67)); bad_store();
    sw_exp(5'd23, 12'h464, "R10 register jump", p_jalr + 32'd4);

    // unimplemented encodings
    emit(32'hFFFF_FFFF);
    emit(e_r(7'h01, 5'd2, 5'd1, 3'd0, 5'd20));
    emit(e_i(12'h400, 5'd0, 3'd3, 5'd20, 7'h03));
    emit(e_s(12'h7F0, 5'd1, 5'd0, 3'd3));
    emit(e_b(13'd8, 5'd0, 5'd0, 3'd2));
    emit(e_i(12'h0FF, 5'd0, 3'd5, 5'd20, 7'h13) | 32'h0200_0000); // srli bad funct7
    sw_exp(5'd20, 12'h468, "R12 no-op encodings", 32'd8);
    p_end = here();
    emit(e_j(21'd0, 5'd0));

    repeat (4) @(negedge clk);
    rst = 1'b0;

    while (exp_q.size() != 0 && cyc < WDOG) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d pending expected 0", exp_q.size());
    end
    repeat (80) @(negedge clk);
    #2;
    chk("R10 self loop fetch", last_fetch, p_end);
    chk("R4/R12 scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule